// File: doc/BRIEF.md
# I2C Byte-Command Master Engine

This block is a single-master I2C controller that software steps through a transfer one byte at a time. Each write to its 12-bit command port launches exactly one operation: a START followed by an address byte, a data byte sent to the slave, a data byte received from the slave, or a STOP on its own. One command word holds the START and STOP requests, the acknowledge-suppress flag, the per-operation interrupt enable and the byte itself. When the operation finishes, the engine updates a registered 16-bit status word. If that command asked for an interrupt, the engine also raises a single-cycle interrupt pulse.

The engine drives SCL and SDA as open-drain lines. It only ever pulls a line low and reads both lines back through a synchronizer. A bus monitor watches the lines for START and STOP conditions from any master and reports whether the bus is free. When the engine releases SDA high but sees it low while SCL is high, it has lost arbitration. It then lets go of both lines and flags the loss. The read/write bit of the most recent address byte decides whether later byte commands send or receive. A START that arrives while the engine still owns the bus produces a repeated START.

Top module: `i2c_bcm_master`

## Requirements
- R1: Command word layout: bit 11 requests the completion interrupt, bit 10 requests a START before the byte, bit 9 requests a STOP, bit 8 suppresses the master's acknowledge, and bits 7:0 carry the byte. Status word layout: bit 14 = engine owns the bus, bit 13 = last byte was transmitted, bit 12 = STOP seen since the last START, bit 11 = slave did not acknowledge, bit 10 = operation in progress, bit 9 = arbitration lost, bit 8 = bus free, bits 7:0 = last byte seen on SDA. Bit 15 reads 0.
- R2: A command with bit 10 set generates a START condition (SDA falls while SCL is high) and then transmits the byte. Afterwards bit 14 and bit 13 are 1, and bits 8 and 12 read 0.
- R3: Transmitted bytes go MSB first. The slave's acknowledge is sampled in the ninth clock: a high level there sets bit 11, and a low level leaves it 0.
- R4: When the engine receives, the byte is shifted in MSB first and reported in bits 7:0 with bit 13 = 0. In the ninth clock the master pulls SDA low, unless bit 8 of the command was set, in which case it leaves SDA released.
- R5: A command with bit 9 set and bit 10 clear transfers no byte. It produces a STOP (SDA rises while SCL is high) and leaves bits 7:0 unchanged. Afterwards bit 14 and bit 13 read 0, and bits 12 and 8 read 1.
- R6: Each completed command whose bit 11 was set yields exactly one single-cycle interrupt pulse. In that cycle the status word already holds the result and bit 10 reads 0. A completed command with bit 11 clear yields no pulse.
- R7: If SDA reads low while the engine releases it during a transmitted data bit with SCL high, the engine releases both lines and ends the operation. The status then shows bit 9 = 1 and bit 14 = 0.
- R8: A command written while bit 10 is 1 is ignored. The running operation completes with its own result.
- R9: A command with bit 10 set while the engine still owns the bus produces a repeated START without an intervening STOP. Bit 8 stays 0 and bit 12 stays 0.
- R10: After reset, neither line is driven, the interrupt output is low, and the status word reads 0x0100.
- R11: Byte commands without bit 10 or bit 9 receive when the last address byte had bit 0 = 1, and transmit when it had bit 0 = 0.
- R12: A command with both bit 10 and bit 9 set sends the address byte and then a STOP. It completes with bits 13, 12 and 8 = 1 and bit 14 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 12 | Command word |
| stat_rdata | output | 16 | Registered status word |
| irq_edge | output | 1 | Single-cycle completion pulse |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The bench drives the engine against a behavioural slave that answers one address. It runs full write and read transactions with bytes that include all-ones, alternating and mixed patterns. Comparing each received byte against the slave's known data shows that bit order and direction tracking are correct. The bench also addresses an absent device to separate a slave acknowledge from a missing one, and follows a read with a repeated START to show the bus stays owned without a STOP. Directed cases drive SDA low from outside to force lost arbitration, write a second command while one is in flight, and run a command with the interrupt disabled. These tell the ignore, release and pulse-suppression paths apart from normal completion.

// File: rtl/i2c_bcm_pkg.sv
package i2c_bcm_pkg;
  localparam int CMD_W  = 12;
  localparam int STAT_W = 16;
  localparam int BYTE_W = 8;

  // command fields
  localparam int C_IEN = 11;
  localparam int C_STA = 10;
  localparam int C_STO = 9;
  localparam int C_NAK = 8;

  // status fields
  localparam int S_MST  = 14;
  localparam int S_TX   = 13;
  localparam int S_STP  = 12;
  localparam int S_NAK  = 11;
  localparam int S_BSY  = 10;
  localparam int S_ARB  = 9;
  localparam int S_FREE = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_STOP, ST_DONE
  } eng_state_t;
endpackage

// File: rtl/i2c_bcm_tick.sv
module i2c_bcm_tick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bcm_monitor.sv
module i2c_bcm_monitor #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic bus_free,
  output logic stop_seen
);
  logic [SYNC_N-1:0] scl_sy, sda_sy;
  logic sda_d;
  logic scl_s;
  logic start_det, stop_det;

  assign scl_s = scl_sy[SYNC_N-1];
  assign sda_s = sda_sy[SYNC_N-1];
  assign start_det = scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_s & ~sda_d & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy    <= '1;
      sda_sy    <= '1;
      sda_d     <= 1'b1;
      bus_free  <= 1'b1;
      stop_seen <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC_N-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_N-2:0], sda_in};
      sda_d  <= sda_s;
      if (start_det) begin
        bus_free  <= 1'b0;
        stop_seen <= 1'b0;
      end else if (stop_det) begin
        bus_free  <= 1'b1;
        stop_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bcm_engine.sv
module i2c_bcm_engine
  import i2c_bcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accept,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              sda_s,
  output logic              busy,
  output logic              run,
  output logic              scl_lo,
  output logic              sda_lo,
  output logic              own,
  output logic              res_tx,
  output logic              res_nack,
  output logic              res_arb,
  output logic              irq_req,
  output logic [BYTE_W-1:0] res_data
);
  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_W);

  eng_state_t      state;
  logic [1:0]      q;
  logic [BW-1:0]   bitn;
  logic [BYTE_W-1:0] txsh, rxsh;
  logic is_rx, noack, want_stop, dir_rd, ien, stop_only;

  assign busy = (state != ST_IDLE);
  assign run  = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      q         <= '0;
      bitn      <= '0;
      txsh      <= '0;
      rxsh      <= '0;
      is_rx     <= 1'b0;
      noack     <= 1'b0;
      want_stop <= 1'b0;
      dir_rd    <= 1'b0;
      ien       <= 1'b0;
      stop_only <= 1'b0;
      scl_lo    <= 1'b0;
      sda_lo    <= 1'b0;
      own       <= 1'b0;
      res_tx    <= 1'b0;
      res_nack  <= 1'b0;
      res_arb   <= 1'b0;
      res_data  <= '0;
      irq_req   <= 1'b0;
    end else begin
      irq_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ien      <= cmd[C_IEN];
            noack    <= cmd[C_NAK];
            txsh     <= cmd[BYTE_W-1:0];
            q        <= '0;
            bitn     <= '0;
            res_nack <= 1'b0;
            res_arb  <= 1'b0;
            if (cmd[C_STA]) begin
              state     <= ST_START;
              is_rx     <= 1'b0;
              dir_rd    <= cmd[0];
              want_stop <= cmd[C_STO];
              stop_only <= 1'b0;
              res_tx    <= 1'b1;
            end else if (cmd[C_STO]) begin
              state     <= ST_STOP;
              want_stop <= 1'b1;
              stop_only <= 1'b1;
              res_tx    <= 1'b0;
            end else begin
              state     <= ST_BIT;
              is_rx     <= dir_rd;
              want_stop <= 1'b0;
              stop_only <= 1'b0;
              res_tx    <= ~dir_rd;
            end
          end
        end
        ST_START: begin
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                sda_lo <= 1'b1;
                own    <= 1'b1;
              end
              default: begin
                scl_lo <= 1'b1;
                state  <= ST_BIT;
              end
            endcase
          end
        end
        ST_BIT: begin
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_lo <= (bitn == ACK_IDX) ? (is_rx & ~noack)
                                                : (~is_rx & ~txsh[BYTE_W-1]);
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (bitn != ACK_IDX) rxsh <= {rxsh[BYTE_W-2:0], sda_s};
                else if (!is_rx) res_nack <= sda_s;
                if (!is_rx && (bitn != ACK_IDX) && !sda_lo && !sda_s) begin
                  res_arb <= 1'b1;
                  own     <= 1'b0;
                  scl_lo  <= 1'b0;
                  sda_lo  <= 1'b0;
                  state   <= ST_DONE;
                end
              end
              default: begin
                scl_lo <= 1'b1;
                txsh   <= txsh << 1;
                if (bitn == ACK_IDX) begin
                  bitn  <= '0;
                  state <= want_stop ? ST_STOP : ST_DONE;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
            endcase
          end
        end
        ST_STOP: begin
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: begin
                own   <= 1'b0;
                state <= ST_DONE;
              end
            endcase
          end
        end
        ST_DONE: begin
          if (!stop_only) res_data <= rxsh;
          irq_req <= ien;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bcm_master.sv
module i2c_bcm_master
  import i2c_bcm_pkg::*;
#(
  parameter int QDIV   = 125,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq_edge,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  logic tick, run, busy, accept, sda_s, bus_free, stop_seen;
  logic own, res_tx, res_nack, res_arb, irq_req;
  logic [BYTE_W-1:0] res_data;
  logic [STAT_W-1:0] stat_nxt;

  assign accept = cmd_we & ~busy;

  i2c_bcm_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  i2c_bcm_monitor #(.SYNC_N(SYNC_N)) u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .bus_free(bus_free), .stop_seen(stop_seen)
  );

  i2c_bcm_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick), .accept(accept), .cmd(cmd_wdata),
    .sda_s(sda_s), .busy(busy), .run(run), .scl_lo(scl_drive_low),
    .sda_lo(sda_drive_low), .own(own), .res_tx(res_tx), .res_nack(res_nack),
    .res_arb(res_arb), .irq_req(irq_req), .res_data(res_data)
  );

  always_comb begin
    stat_nxt               = '0;
    stat_nxt[S_MST]        = own;
    stat_nxt[S_TX]         = res_tx;
    stat_nxt[S_STP]        = stop_seen;
    stat_nxt[S_NAK]        = res_nack;
    stat_nxt[S_BSY]        = busy;
    stat_nxt[S_ARB]        = res_arb;
    stat_nxt[S_FREE]       = bus_free;
    stat_nxt[BYTE_W-1:0]   = res_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rdata         <= '0;
      stat_rdata[S_FREE] <= 1'b1;
      irq_edge           <= 1'b0;
    end else begin
      stat_rdata <= stat_nxt;
      irq_edge   <= irq_req;
    end
  end
endmodule

// File: rtl/i2c_bcm_checker.sv
module i2c_bcm_checker (
  input logic        clk,
  input logic        rst,
  input logic        irq_edge,
  input logic [15:0] stat_rdata,
  input logic        scl_drive_low,
  input logic        sda_drive_low
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_edge |=> !irq_edge);

  a_r6_idle_at_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_edge |-> !stat_rdata[10]);

  a_r7_lines_released: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_rdata[9]) |-> (!scl_drive_low && !sda_drive_low));

  a_r5_free_with_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_rdata[8]) |-> stat_rdata[12]);

  a_r2_start_clears_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_rdata[8]) |-> !stat_rdata[12]);
endmodule

bind i2c_bcm_master i2c_bcm_checker u_chk (
  .clk(clk), .rst(rst), .irq_edge(irq_edge), .stat_rdata(stat_rdata),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_bcm_master_test.sv
module i2c_bcm_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [11:0] cmd_wdata = '0;
  logic [15:0] stat_rdata;
  logic irq_edge, scl_drive_low, sda_drive_low;
  logic s_drv = 1'b0;
  logic force_low = 1'b0;
  wire  scl_line = ~scl_drive_low;
  wire  sda_line = ~(sda_drive_low | s_drv | force_low);

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  i2c_bcm_master #(.QDIV(5), .SYNC_N(2)) uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_rdata(stat_rdata), .irq_edge(irq_edge), .scl_in(scl_line),
    .sda_in(sda_line), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  // behavioural slave at address 0x50, read data A5 then 3C
  int sbit = 15;
  int ridx = 0;
  logic s_addr = 1'b0, s_sel = 1'b0, s_rd = 1'b0, m_ack = 1'b0;
  logic [7:0] sh = '0, txb = '0;

  function automatic logic [7:0] rd_byte(int i);
    return (i == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    sbit = 15; s_addr = 1'b1; s_sel = 1'b0; s_drv = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    sbit = 15; s_sel = 1'b0; s_drv = 1'b0;
  end
  always @(posedge scl_line) begin
    if (sbit < 8) sh = {sh[6:0], sda_line};
    else if (sbit == 8) m_ack = !sda_line;
  end
  always @(negedge scl_line) begin
    if (sbit == 15) sbit = 0;
    else if (sbit == 8) begin
      sbit = 0;
      if (s_sel && s_rd && m_ack) begin
        txb = rd_byte(ridx); ridx++; s_drv = !txb[7];
      end else s_drv = 1'b0;
    end else begin
      sbit = sbit + 1;
      if (sbit == 8) begin
        if (s_addr) begin
          s_addr = 1'b0; s_sel = (sh[7:1] == 7'h50); s_rd = sh[0];
          s_drv = s_sel; ridx = 0;
        end else s_drv = s_sel && !s_rd;
      end else if (s_sel && s_rd && !s_addr) s_drv = !txb[7-sbit];
    end
  end

  task automatic check(input bit ok, input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [11:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_irq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq_edge) begin got = 1'b1; break; end
    end
  endtask

  // {command, expected status}
  localparam logic [27:0] VEC [12] = '{
    28'hDA060A0,  // R2 address write to 0x50
    28'h93C603C,  // R3 write 3C
    28'h9FF60FF,  // R3 write FF
    28'hB0011FF,  // R5 stop only
    28'hDA160A1,  // R11 address read
    28'h80040A5,  // R4 read with ack
    28'h900403C,  // R4 last read, no ack
    28'hDA060A0,  // R9 repeated start
    28'hB0011A0,  // R5 stop
    28'hD466846,  // R3 absent slave, nack
    28'hB001146,  // R5 stop after nack
    28'hFA031A0   // R12 address plus stop, R1 layout throughout
  };
  localparam int VREQ [12] = '{2, 3, 3, 5, 11, 4, 4, 9, 5, 3, 5, 12};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    bit seen_irq;
    bit was_busy;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(stat_rdata == 16'h0100, 10, stat_rdata, 16'h0100);
    check(!scl_drive_low && !sda_drive_low, 10, {14'd0, scl_drive_low, sda_drive_low}, 16'h0);
    check(!irq_edge, 10, {15'd0, irq_edge}, 16'h0);

    for (int v = 0; v < 12; v++) begin
      put_cmd(VEC[v][27:16]);
      wait_irq(got);
      check(got, 6, {15'd0, got}, 16'h1);
      check(stat_rdata == VEC[v][15:0], VREQ[v], stat_rdata, VEC[v][15:0]);
      repeat (3) @(negedge clk);
    end

    // R6 no pulse when interrupt enable is clear
    seen_irq = 1'b0; was_busy = 1'b0;
    put_cmd(12'h5A0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq_edge) seen_irq = 1'b1;
      if (stat_rdata[10]) was_busy = 1'b1;
      else if (was_busy) break;
    end
    repeat (5) @(negedge clk);
    check(!seen_irq, 6, {15'd0, seen_irq}, 16'h0);
    check(stat_rdata == 16'h60A0, 6, stat_rdata, 16'h60A0);
    put_cmd(12'hB00);
    wait_irq(got);
    check(stat_rdata == 16'h11A0, 5, stat_rdata, 16'h11A0);

    // R8 second command during operation is ignored
    put_cmd(12'hDA0);
    wait_irq(got);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 12'h977;
    @(negedge clk); cmd_wdata = 12'hB00;
    @(negedge clk); cmd_we = 1'b0;
    check(stat_rdata[10], 8, stat_rdata, 16'h0400);
    wait_irq(got);
    check(stat_rdata == 16'h6077, 8, stat_rdata, 16'h6077);
    put_cmd(12'hB00);
    wait_irq(got);
    check(stat_rdata == 16'h1177, 8, stat_rdata, 16'h1177);

    // R7 arbitration lost against another master holding SDA low
    force_low = 1'b1;
    repeat (10) @(negedge clk);
    put_cmd(12'hDFE);
    wait_irq(got);
    check(got, 7, {15'd0, got}, 16'h1);
    check((stat_rdata & 16'hFF00) == 16'h2200, 7, stat_rdata & 16'hFF00, 16'h2200);
    check(!scl_drive_low && !sda_drive_low, 7, {14'd0, scl_drive_low, sda_drive_low}, 16'h0);
    force_low = 1'b0;
    repeat (10) @(negedge clk);
    check((stat_rdata & 16'h1100) == 16'h1100, 5, stat_rdata & 16'h1100, 16'h1100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule